// File: doc/BRIEF.md
# Suspend State Controller

This block owns the single output that places the system in its low-power suspend state. While the output is high, only the standby rail carries power. When the output drops, the main rails come back. Two things can drive the output high:

- a write strobe from the bus to the suspend command port;
- a high level on an asynchronous positive-sense input, but only while the trigger enable bit is set.

Only four wake sources can bring the output back low: ring indicate, real-time clock alarm, an active-low hotkey and the cover switch.

All asynchronous inputs pass through two-flop synchronisers. A wake acts on the edge at which its source becomes active, never on a level that is held. A wake only counts while the output is high. The positive-sense input has to return low after a wake before it can start another suspend. This keeps the block from dropping straight back into suspend. All pins are plain control pins. There is no data stream and no handshake.

Top module: `sleep_state_ctrl`

## Requirements
- R1: After reset, `sleep_out` is 0.
- R2: A cycle with `cmd_wr` high sets `sleep_out` to 1 at the next clock edge, unless a wake takes effect in that cycle.
- R3: When `trig_en` is 1, a high level on `pos_in` sets `sleep_out`.
- R4: When `trig_en` is 0, `pos_in` has no effect on `sleep_out`.
- R5: While `sleep_out` is 1, any of these clears it: a rising edge on `ring_in`, `alarm_in` or `cover_in`, or a falling edge on `hotkey_n`.
- R6: A wake input that is held in its active state does not clear `sleep_out` again. Only a new transition into the active state counts.
- R7: A wake transition while `sleep_out` is 0 is ignored. It does not clear a suspend that is entered later.
- R8: If a wake and an entry request fall in the same cycle while `sleep_out` is 1, the wake wins and `sleep_out` goes to 0.
- R9: After a wake, `pos_in` must be seen low before it can set `sleep_out` again.
- R10: A change on an asynchronous input affects `sleep_out` at the third rising clock edge after the change. This covers two synchroniser stages plus the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Synchronous strobe: write to the suspend command port |
| trig_en | input | 1 | Enable for the positive-sense trigger |
| pos_in | input | 1 | Asynchronous positive-sense suspend trigger |
| ring_in | input | 1 | Asynchronous ring indicate wake, active high |
| alarm_in | input | 1 | Asynchronous real-time clock alarm wake, active high |
| hotkey_n | input | 1 | Asynchronous hotkey wake, active low |
| cover_in | input | 1 | Asynchronous cover switch wake, active high |
| sleep_out | output | 1 | Suspend state; 1 means only the standby rail is powered |

## Verification
Entry and wake can land on the same clock edge. Entry comes from a command write or the gated trigger. Wake comes from a synchronised edge on any of the four sources.

The bench provokes this collision on purpose. It drives a wake source and then raises `cmd_wr` exactly two cycles later, so the strobe meets the synchronised edge. It expects `sleep_out` to fall. Random stimulus produces many more such collisions, with the trigger both armed and disarmed. Each outcome is judged against a cycle model in the bench that applies "wake wins when suspended".

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  localparam int unsigned NUM_WAKE    = 4;
  localparam int unsigned SYNC_STAGES = 2;
  // Wake vector order: ring, alarm, hotkey, cover
  localparam int unsigned WK_RING   = 0;
  localparam int unsigned WK_ALARM  = 1;
  localparam int unsigned WK_HOTKEY = 2;
  localparam int unsigned WK_COVER  = 3;
  localparam logic [NUM_WAKE-1:0] WAKE_ACT_LOW = 4'b0100;
  typedef logic [NUM_WAKE-1:0] wake_vec_t;
endpackage

// File: rtl/sleep_sync.sv
module sleep_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d_in;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/sleep_wake_edge.sv
module sleep_wake_edge #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] evt
);
  logic [W-1:0] lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= '0;
    else        lvl_d <= lvl;
  end

  assign evt = lvl & ~lvl_d;

  // R6: an event never repeats on consecutive cycles for the same source
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((evt & $past(evt)) == '0));
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm #(
  parameter int unsigned NW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic          trig_en,
  input  logic          pos_lvl,
  input  logic [NW-1:0] wake_evt,
  output logic          sleep_q
);
  logic armed_q;
  logic wake_any, trig_req, enter, wake_hit;

  assign wake_any = |wake_evt;
  assign trig_req = trig_en & pos_lvl & armed_q;
  assign enter    = cmd_wr | trig_req;
  assign wake_hit = sleep_q & wake_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      if (wake_hit)   sleep_q <= 1'b0;
      else if (enter) sleep_q <= 1'b1;
      if (wake_hit)      armed_q <= 1'b0;
      else if (!pos_lvl) armed_q <= 1'b1;
    end
  end

  assert_cmd_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !wake_any) |=> sleep_q);
  assert_wake_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_q && wake_any) |=> !sleep_q);
  assert_wake_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_q && wake_any && cmd_wr) |=> !sleep_q);
  assert_rise_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_q) |-> $past(cmd_wr || (trig_en && pos_lvl)));
  assert_fall_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_q) |-> $past(wake_any));
  assert_no_retrigger_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_q && wake_any) ##1 (pos_lvl && !cmd_wr) |=> !sleep_q);
endmodule

// File: rtl/sleep_state_ctrl.sv
module sleep_state_ctrl
  import sleep_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_wr,
  input  logic trig_en,
  input  logic pos_in,
  input  logic ring_in,
  input  logic alarm_in,
  input  logic hotkey_n,
  input  logic cover_in,
  output logic sleep_out
);
  localparam int unsigned NSYNC = NUM_WAKE + 1;

  wake_vec_t        wake_raw, wake_act, wake_evt;
  logic [NSYNC-1:0] sync_in, sync_out;

  assign wake_raw[WK_RING]   = ring_in;
  assign wake_raw[WK_ALARM]  = alarm_in;
  assign wake_raw[WK_HOTKEY] = hotkey_n;
  assign wake_raw[WK_COVER]  = cover_in;

  genvar i;
  generate
    for (i = 0; i < NUM_WAKE; i++) begin : g_pol
      if (WAKE_ACT_LOW[i]) begin : g_low
        assign wake_act[i] = ~wake_raw[i];
      end else begin : g_high
        assign wake_act[i] = wake_raw[i];
      end
    end
  endgenerate

  assign sync_in = {pos_in, wake_act};

  sleep_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(sync_in), .q_out(sync_out)
  );

  sleep_wake_edge #(.W(NUM_WAKE)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sync_out[NUM_WAKE-1:0]), .evt(wake_evt)
  );

  sleep_fsm #(.NW(NUM_WAKE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .trig_en(trig_en),
    .pos_lvl(sync_out[NUM_WAKE]), .wake_evt(wake_evt), .sleep_q(sleep_out)
  );
endmodule

// File: tb/tb_sleep_state_ctrl.sv
module tb_sleep_state_ctrl;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cmd_wr, trig_en, pos_in, ring_in, alarm_in, hotkey_n, cover_in;
  logic sleep_out;

  sleep_state_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .trig_en(trig_en),
    .pos_in(pos_in), .ring_in(ring_in), .alarm_in(alarm_in),
    .hotkey_n(hotkey_n), .cover_in(cover_in), .sleep_out(sleep_out)
  );

  int tests = 0, fails = 0;
  logic [4:0] m_s1, m_s2;
  logic [3:0] m_prev;
  logic m_sleep, m_armed;

  function automatic logic [4:0] raw_vec();
    return {pos_in, cover_in, ~hotkey_n, alarm_in, ring_in};
  endfunction

  function automatic logic next_sleep(logic sl, logic armed, logic [4:0] s2,
                                      logic [3:0] prev, logic wr, logic en);
    logic wk;
    wk = |(s2[3:0] & ~prev);
    if (sl && wk) return 1'b0;
    if (wr || (en && s2[4] && armed)) return 1'b1;
    return sl;
  endfunction

  task automatic model_reset();
    m_s1 = '0; m_s2 = '0; m_prev = '0; m_sleep = 1'b0; m_armed = 1'b1;
  endtask

  task automatic model_edge();
    logic wk;
    wk = m_sleep && |(m_s2[3:0] & ~m_prev);
    m_sleep = next_sleep(m_sleep, m_armed, m_s2, m_prev, cmd_wr, trig_en);
    if (wk) m_armed = 1'b0;
    else if (!m_s2[4]) m_armed = 1'b1;
    m_prev = m_s2[3:0];
    m_s2 = m_s1;
    m_s1 = raw_vec();
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: sleep_out=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(sleep_out, m_sleep, tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int k = 0; k < n; k++) tick(tag);
  endtask

  task automatic set_wake(input int idx, input logic act);
    case (idx)
      0: ring_in  = act;
      1: alarm_in = act;
      2: hotkey_n = ~act;
      default: cover_in = act;
    endcase
  endtask

  task automatic do_cmd();
    cmd_wr = 1'b1; tick("R2"); cmd_wr = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: run hung, sleep_out=%0b expected finish", sleep_out);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_wr = 0; trig_en = 0; pos_in = 0;
    ring_in = 0; alarm_in = 0; hotkey_n = 1; cover_in = 0;
    model_reset();
    repeat (3) @(negedge clk);
    chk(sleep_out, 1'b0, "R1");
    rst_n = 1'b1;
    ticks(3, "R1");
    chk(sleep_out, 1'b0, "R1");

    // R2 and R5: enter by command, wake by each source, R10 latency
    for (int w = 0; w < 4; w++) begin
      do_cmd();
      chk(sleep_out, 1'b1, "R2");
      set_wake(w, 1'b1);
      ticks(2, "R10");
      chk(sleep_out, 1'b1, "R10");
      tick("R5");
      chk(sleep_out, 1'b0, "R5");
      set_wake(w, 1'b0);
      ticks(3, "R5");
    end

    // R4: trigger disabled
    trig_en = 0; pos_in = 1;
    ticks(6, "R4");
    chk(sleep_out, 1'b0, "R4");
    pos_in = 0; ticks(3, "R4");

    // R3 with latency, then R9
    trig_en = 1; pos_in = 1;
    ticks(2, "R10");
    chk(sleep_out, 1'b0, "R10");
    tick("R3");
    chk(sleep_out, 1'b1, "R3");
    ring_in = 1; ticks(3, "R5");
    chk(sleep_out, 1'b0, "R5");
    ring_in = 0;
    ticks(6, "R9");
    chk(sleep_out, 1'b0, "R9");
    pos_in = 0; ticks(3, "R9");
    pos_in = 1; ticks(3, "R9");
    chk(sleep_out, 1'b1, "R9");
    pos_in = 0;
    cover_in = 1; ticks(3, "R5");
    cover_in = 0; ticks(3, "R5");
    trig_en = 0;

    // R7: wake while awake is ignored
    alarm_in = 1; ticks(4, "R7");
    alarm_in = 0; ticks(3, "R7");
    do_cmd();
    ticks(5, "R7");
    chk(sleep_out, 1'b1, "R7");

    // R6: held wake does not clear again
    cover_in = 1; ticks(3, "R6");
    chk(sleep_out, 1'b0, "R6");
    do_cmd();
    ticks(5, "R6");
    chk(sleep_out, 1'b1, "R6");
    cover_in = 0; ticks(3, "R6");
    chk(sleep_out, 1'b1, "R6");

    // R8: wake and command collide
    hotkey_n = 0; ticks(2, "R8");
    cmd_wr = 1; tick("R8"); cmd_wr = 0;
    chk(sleep_out, 1'b0, "R8");
    hotkey_n = 1; ticks(3, "R8");

    // Random phase
    void'($urandom(32'h5EED_1234));
    for (int c = 0; c < 4000; c++) begin
      cmd_wr = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 31) == 0) trig_en  = ~trig_en;
      if ($urandom_range(0, 9)  == 0) pos_in   = ~pos_in;
      if ($urandom_range(0, 11) == 0) ring_in  = ~ring_in;
      if ($urandom_range(0, 11) == 0) alarm_in = ~alarm_in;
      if ($urandom_range(0, 11) == 0) hotkey_n = ~hotkey_n;
      if ($urandom_range(0, 11) == 0) cover_in = ~cover_in;
      tick("R8 random");
    end
    cmd_wr = 0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule